// File: doc/BRIEF.md
# Mode-Gated Serial Register Slave

This block is a full-duplex serial slave sitting between a host controller and a small register file. The host lowers an active-low select line and clocks a frame on SCK. While a control word shifts in on MOSI, a status word comes back on MISO: a fixed header carrying the current operating mode, then the contents of the addressed register. A frame can be marked read-only, so status can always be fetched without side effects.

Writes are gated. At the end of a complete frame the block checks the frame length, the read-only flag and whether the present operating mode permits access to the target address. Only then does it pulse a single-cycle write strobe towards the register file. Operational registers are writable in the two running modes. The configuration registers at the top of the address space are writable only in the two boot-time modes.

All serial inputs are synchronised into the system clock domain, which must run at least eight times faster than SCK. MISO comes with a separate output-enable, so that a pad can release the line while select is high.

Top module: `modespi_regslave`

## Requirements
- R1: A frame is 16 bits, MSB first: 3 address bits, 1 read-only flag, then 12 data bits. A committed write presents that address on reg_addr and that data on reg_wdata.
- R2: MOSI is sampled on falling SCK edges (SCK idles high). A MOSI change between a falling edge and the next rising edge has no effect.
- R3: MISO carries 4 header bits {1, 0, mode[1], mode[0]}, then the 12 bits of reg_rdata for the frame's address, MSB first. Bit 0 appears after select falls, and each later bit changes after a rising SCK edge.
- R4: miso_oe is 0 while select is high, and 1 from shortly after select falls until select rises.
- R5: A frame with the read-only flag set to 1 never causes a write.
- R6: A frame with fewer or more than 16 falling SCK edges never causes a write.
- R7: Addresses 0 to 5 are written only when mode is 2 (normal) or 3 (standby).
- R8: Addresses 6 and 7 are written only when mode is 0 (start-up) or 1 (restart).
- R9: reg_we is a single-cycle pulse that follows the rising edge of select.
- R10: After reset, reg_we is 0, miso_oe is 0 and reg_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idle high |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial status data to the host |
| miso_oe | output | 1 | Drive enable for the MISO pad |
| mode | input | 2 | Operating mode: 0 start-up, 1 restart, 2 normal, 3 standby |
| reg_we | output | 1 | Register file write strobe |
| reg_addr | output | 3 | Register file address (address of the current frame) |
| reg_wdata | output | 12 | Register file write data |
| reg_rdata | input | 12 | Contents of the register at reg_addr |

## Verification
The bench builds the block with its defaults: 3 address bits, 12 data bits, configuration registers starting at address 6, and two synchroniser stages. With these values both address classes can be tried in all four modes, and every write is then read back through the status stream. The bench also drives frames of 12 and 17 clocks against the 16-bit length check. After every falling edge it flips MOSI to a wrong value before the next rising edge, so a slave that sampled on the wrong edge would corrupt the written data.

// File: rtl/modespi_pkg.sv
package modespi_pkg;

  typedef enum logic [1:0] {
    MD_STARTUP = 2'd0,
    MD_RESTART = 2'd1,
    MD_NORMAL  = 2'd2,
    MD_STANDBY = 2'd3
  } op_mode_e;

  localparam int unsigned MODE_W = 2;

  // Address at or above cfg_base: boot-time modes only; below: running modes only.
  function automatic logic access_ok(input int unsigned addr,
                                     input int unsigned cfg_base,
                                     input op_mode_e m);
    if (addr >= cfg_base) return (m == MD_STARTUP) || (m == MD_RESTART);
    return (m == MD_NORMAL) || (m == MD_STANDBY);
  endfunction

  // Status header: marker 1, zero fill, then the mode bits.
  function automatic logic [7:0] status_header(input op_mode_e m);
    return {6'b000010, m};
  endfunction

endpackage

// File: rtl/modespi_sync.sv
module modespi_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= RST_VAL;
      else if (s == 0) st[s] <= d;
      else st[s] <= st[(s == 0) ? 0 : s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/modespi_rx.sv
module modespi_rx #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 12,
  localparam int FRAME = ADDR_W + 1 + DATA_W,
  localparam int CNT_W = $clog2(FRAME + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  output logic              sck_rise,
  output logic              sck_fall,
  output logic              cs_fall,
  output logic              cs_rise,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [ADDR_W-1:0] addr_q,
  output logic [FRAME-1:0]  rx_word
);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME + 1);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W - 1);

  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b1;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_n_s;
    end
  end

  assign sck_fall = sck_d & ~sck_s & ~cs_n_s;
  assign sck_rise = ~sck_d & sck_s & ~cs_n_s;
  assign cs_fall  = cs_d & ~cs_n_s;
  assign cs_rise  = ~cs_d & cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_word <= '0;
      addr_q  <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      rx_word <= '0;
    end else if (sck_fall) begin
      rx_word <= {rx_word[FRAME-2:0], mosi_s};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CNT_ADDR) addr_q <= {rx_word[ADDR_W-2:0], mosi_s};
    end
  end

  // Address only moves on the falling edge that completes the address field (R1)
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_fall && bit_cnt == CNT_ADDR && !cs_fall) |=> $stable(addr_q));

  // Length counter never runs past its saturation value (R6)
  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_SAT);
endmodule

// File: rtl/modespi_tx.sv
module modespi_tx #(
  parameter int HDR_W = 4,
  parameter int DATA_W = 12,
  localparam int FRAME = HDR_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [HDR_W-1:0]  header,
  input  logic [DATA_W-1:0] rdata,
  output logic              miso,
  output logic              miso_oe
);
  logic [FRAME-1:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      miso_oe <= 1'b0;
    end else if (cs_fall) begin
      tx_sr   <= {header, {DATA_W{1'b0}}};
      miso_oe <= 1'b1;
    end else if (cs_rise) begin
      miso_oe <= 1'b0;
    end else if (sck_rise) begin
      if (bit_cnt == CNT_W'(HDR_W)) tx_sr <= {rdata, {HDR_W{1'b0}}};
      else                          tx_sr <= {tx_sr[FRAME-2:0], 1'b0};
    end
  end

  assign miso = tx_sr[FRAME-1];

  p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !miso_oe);

  p_oe_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> miso_oe);

  // First status bit is the marker (R3)
  p_hdr_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> miso);
endmodule

// File: rtl/modespi_regslave.sv
module modespi_regslave
  import modespi_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 12,
  parameter int CFG_BASE = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic [1:0]        mode,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int HDR_W = ADDR_W + 1;
  localparam int FRAME = HDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 2);

  logic sck_s, cs_n_s, mosi_s;
  logic sck_rise_evt, sck_fall_evt, cs_fall_evt, cs_rise_evt;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [FRAME-1:0]  rx_word;
  logic [HDR_W-1:0]  header;
  logic              frame_full, ro_flag, mode_ok, commit_evt;

  modespi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, cs_n, mosi}), .q({sck_s, cs_n_s, mosi_s})
  );

  modespi_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .sck_rise(sck_rise_evt), .sck_fall(sck_fall_evt),
    .cs_fall(cs_fall_evt), .cs_rise(cs_rise_evt),
    .bit_cnt(bit_cnt), .addr_q(addr_q), .rx_word(rx_word)
  );

  assign header = HDR_W'(status_header(op_mode_e'(mode)));

  modespi_tx #(.HDR_W(HDR_W), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall_evt), .cs_rise(cs_rise_evt),
    .sck_rise(sck_rise_evt), .bit_cnt(bit_cnt), .header(header),
    .rdata(reg_rdata), .miso(miso), .miso_oe(miso_oe)
  );

  assign frame_full = (bit_cnt == CNT_W'(FRAME));
  assign ro_flag    = rx_word[DATA_W];
  assign mode_ok    = access_ok(int'(addr_q), CFG_BASE, op_mode_e'(mode));
  assign commit_evt = cs_rise_evt & frame_full & ~ro_flag & mode_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= commit_evt;
      if (commit_evt) reg_wdata <= rx_word[DATA_W-1:0];
    end
  end

  assign reg_addr = addr_q;

  p_we_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_we_after_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(cs_rise_evt));

  p_we_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ($past(bit_cnt) == CNT_W'(FRAME)));

  p_we_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !$past(rx_word[DATA_W]));

  p_norm_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && int'(reg_addr) < CFG_BASE) |-> $past(mode[1]));

  p_cfg_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && int'(reg_addr) >= CFG_BASE) |-> !$past(mode[1]));
endmodule

// File: tb/modespi_regslave_bench.sv
module modespi_regslave_bench;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, reg_we;
  logic [1:0]  mode = 2'd2;
  logic [2:0]  reg_addr;
  logic [11:0] reg_wdata, reg_rdata;
  logic [11:0] regs [8];

  int n_checks = 0, n_fail = 0;
  logic [14:0] exp_q [$];

  always #(CLK_P/2) clk = ~clk;

  assign reg_rdata = regs[reg_addr];

  modespi_regslave u_modespi_regslave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .mode(mode), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic may_write(input logic [2:0] a, input logic [1:0] m);
    if (a >= 3'd6) return m < 2'd2;   // R8
    return m >= 2'd2;                 // R7
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: register file plus write comparison
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      regs[reg_addr] = reg_wdata;
      if (exp_q.size() == 0)
        chk(1'b0, "R5/R6/R7/R8 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R1 write content", {reg_addr, reg_wdata}, e);
      end
      @(negedge clk);
      chk(!reg_we, "R9 single pulse", reg_we, 0);
    end
  end

  // Driver: one frame of nbits clocks, status compared against header plus register
  task automatic xfer(input logic [2:0] a, input logic ro, input logic [11:0] d,
                      input int nbits, input string req);
    logic [15:0] word, got, expw;
    int nc;
    word = {a, ro, d};
    expw = {2'b10, mode, regs[a]};
    got  = '0;
    if (nbits == 16 && !ro && may_write(a, mode)) exp_q.push_back({a, d});
    cs_n = 1'b0;
    wait_clk(2 * HALF);
    chk(miso_oe, "R4 oe on", miso_oe, 1);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? word[15-i] : 1'b0;
      wait_clk(HALF);
      if (i < 16) got[15-i] = miso;
      sck = 1'b0;
      wait_clk(HALF);
      mosi = ~mosi;           // R2: garbage after the falling edge
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(10);
    nc = (nbits < 16) ? nbits : 16;
    chk((got >> (16 - nc)) == (expw >> (16 - nc)), {"R3 status ", req},
        int'(got), int'(expw));
    chk(!miso_oe, "R4 oe off", miso_oe, 0);
    chk(exp_q.size() == 0, {"R1/R2 write done ", req}, exp_q.size(), 0);
  endtask

  task automatic readback(input logic [2:0] a, input logic [11:0] v, input string req);
    chk(regs[a] == v, req, regs[a], v);
    xfer(a, 1'b1, 12'h000, 16, req);   // read-only frame shows value on MISO
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 12'(i * 12'h111);
    wait_clk(3);
    // R10 reset state
    chk(!reg_we, "R10 reg_we", reg_we, 0);
    chk(!miso_oe, "R10 miso_oe", miso_oe, 0);
    chk(reg_addr == 3'd0, "R10 reg_addr", reg_addr, 0);
    rst_n = 1'b1;
    wait_clk(4);

    mode = 2'd2;
    xfer(3'd1, 1'b0, 12'hA5C, 16, "R7 normal write");
    readback(3'd1, 12'hA5C, "R3 readback");
    xfer(3'd1, 1'b1, 12'h333, 16, "R5 read-only");
    readback(3'd1, 12'hA5C, "R5 unchanged");
    xfer(3'd6, 1'b0, 12'hFFF, 16, "R8 cfg blocked in normal");
    readback(3'd6, 12'h666, "R8 unchanged");

    mode = 2'd0;
    xfer(3'd6, 1'b0, 12'h3C3, 16, "R8 startup cfg write");
    readback(3'd6, 12'h3C3, "R8 readback");
    xfer(3'd2, 1'b0, 12'h0F0, 16, "R7 blocked in startup");
    readback(3'd2, 12'h222, "R7 unchanged");

    mode = 2'd3;
    xfer(3'd5, 1'b0, 12'h5A5, 16, "R7 standby write");
    readback(3'd5, 12'h5A5, "R7 readback");
    mode = 2'd1;
    xfer(3'd7, 1'b0, 12'h801, 16, "R8 restart write");
    readback(3'd7, 12'h801, "R8 readback");

    mode = 2'd2;
    xfer(3'd3, 1'b0, 12'hBEE, 12, "R6 short frame");
    readback(3'd3, 12'h333, "R6 short unchanged");
    xfer(3'd3, 1'b0, 12'hBEE, 17, "R6 long frame");
    readback(3'd3, 12'h333, "R6 long unchanged");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule